// File: doc/BRIEF.md
# Dual Selectable Data Pointer Unit

This block holds two 16-bit address pointers and a one-bit select register in an 8-bit special-function-register space. Software reaches every pointer byte and the select register through a byte-wide register port with an address, a write enable, write data and combinational read data. A datapath port shows the selected pointer as a 16-bit address, and it can load that pointer with a 16-bit immediate or step it by one.

Every datapath action goes only to the pointer that the select bit names. The upper seven bits of the select register are tied to zero, so an increment of that register just flips the active pointer. A dedicated strobe does the same flip in one cycle. This lets a block copy alternate between a source pointer and a destination pointer without saving and restoring addresses.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset both pointers are 0000h, the select bit is 0, and `ptr_addr` reads 0000h.
- R2: A register write to 82h or 83h sets the low or high byte of pointer 0. A write to 84h or 85h sets the low or high byte of pointer 1. A read of any of these addresses returns that byte in the same cycle.
- R3: At address 86h only write-data bit 0 is stored, as the select bit. A read of 86h returns the select bit in bit 0 and zero in bits 7:1.
- R4: `ptr_addr` always shows pointer 1 when the select bit is 1 and pointer 0 when it is 0.
- R5: `ptr_load_en` loads `ptr_load_val` into the selected pointer and leaves the other pointer unchanged.
- R6: `ptr_inc_en` adds one to the selected pointer modulo 2^16. The carry moves from the low byte into the high byte, and FFFFh wraps to 0000h. The other pointer is unchanged.
- R7: `sel_inc_en` flips the select bit. A register write to 86h in the same cycle wins over the strobe.
- R8: In a cycle where a register write hits a byte of a pointer, any datapath load or increment of that same pointer is dropped. Only the written byte changes.
- R9: When `ptr_load_en` and `ptr_inc_en` are both high, the load is applied and the increment is dropped.
- R10: A read of any address other than 82h to 86h returns 00h.
- R11: A datapath load or increment uses the select bit as it stood before the clock edge, even if the select bit changes at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Register address |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Combinational read data for `reg_addr` |
| ptr_addr | output | 16 | Currently selected pointer |
| ptr_load_en | input | 1 | Load the selected pointer from `ptr_load_val` |
| ptr_load_val | input | 16 | Immediate value for a pointer load |
| ptr_inc_en | input | 1 | Increment the selected pointer |
| sel_inc_en | input | 1 | Flip the select bit |

## Verification
Register reads are combinational. The bench therefore compares `reg_rd_data` against the model state in the same low clock phase in which it sets the address. Writes, loads, increments and select flips take effect at the next rising edge. Each result is checked at the following falling edge, on both `reg_rd_data` and `ptr_addr`, so every action is due exactly one cycle after it is applied. The model advances its state only at the rising edge, using the inputs held across that edge. This makes the same-cycle collisions in R7, R8, R9 and R11 land on a single known cycle.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int PTR_W     = 16;
  localparam int NUM_PTR   = 2;
  localparam int NB        = PTR_W / 8;
  localparam logic [7:0] BASE_ADDR = 8'h82;
  localparam logic [7:0] SEL_ADDR  = 8'h86;
endpackage

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    byte_we,
  input  logic [7:0]       wdata,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc_en,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = (|byte_we) | load_en | inc_en;

  always_comb begin
    ptr_d = ptr_q;
    if (|byte_we) begin
      for (int b = 0; b < NB; b++)
        if (byte_we[b]) ptr_d[b*8 +: 8] = wdata;
    end else if (load_en) begin
      ptr_d = load_val;
    end else if (inc_en) begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R6: increment alone steps by one, wrapping at the top
  a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !load_en && byte_we == '0) |=> ptr_q == $past(ptr_q) + PTR_W'(1));
  // R9: load beats increment
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && byte_we == '0) |=> ptr_q == $past(load_val));
  // R8: byte write keeps the unwritten byte untouched
  a_r8_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we == NB'(1)) |=> ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8]));
  // R5: with no action the pointer holds
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !inc_en && byte_we == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/dptr_sel.sv
module dptr_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic flip_en,
  output logic sel_q
);
  logic sel_d;
  logic sel_en;

  assign sel_en = wr_en | flip_en;

  always_comb begin
    sel_d = sel_q;
    if (wr_en)        sel_d = wr_bit;
    else if (flip_en) sel_d = ~sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_d;
  end

  // R7: strobe alone flips the select bit
  a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_en && !wr_en) |=> sel_q != $past(sel_q));
  // R7: register write wins over strobe
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sel_q == $past(wr_bit));
endmodule

// File: rtl/dptr_rdmux.sv
module dptr_rdmux
  import dptr_pkg::*;
(
  input  logic [7:0]                    addr,
  input  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs,
  input  logic                          sel,
  output logic [7:0]                    rdata
);
  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_PTR; i++)
      for (int b = 0; b < NB; b++)
        if (addr == 8'(int'(BASE_ADDR) + i*NB + b)) rdata = ptrs[i][b*8 +: 8];
    if (addr == SEL_ADDR) rdata = {7'b0, sel};
  end

  // R3: upper select bits always read zero
  always_comb begin
    if (addr == SEL_ADDR)
      a_r3_upper_zero: assert (rdata[7:1] == 7'b0);
  end
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
  import dptr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr_en,
  input  logic [7:0]  reg_wr_data,
  output logic [7:0]  reg_rd_data,
  output logic [15:0] ptr_addr,
  input  logic        ptr_load_en,
  input  logic [15:0] ptr_load_val,
  input  logic        ptr_inc_en,
  input  logic        sel_inc_en
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                          sel_q;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;
  logic                          sel_wr;

  assign sel_wr = reg_wr_en && (reg_addr == SEL_ADDR);

  dptr_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (sel_wr),
    .wr_bit  (reg_wr_data[0]),
    .flip_en (sel_inc_en),
    .sel_q   (sel_q)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic [NB-1:0] byte_we;
    logic          active;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign byte_we[b] = reg_wr_en && (reg_addr == 8'(int'(BASE_ADDR) + i*NB + b));
    end
    assign active = (sel_q == 1'(i));

    dptr_reg u_ptr (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .byte_we  (byte_we),
      .wdata    (reg_wr_data),
      .load_en  (ptr_load_en && active),
      .load_val (ptr_load_val),
      .inc_en   (ptr_inc_en && active),
      .ptr_q    (ptrs[i])
    );
  end

  assign ptr_addr = ptrs[sel_q];

  dptr_rdmux u_rd (
    .addr  (reg_addr),
    .ptrs  (ptrs),
    .sel   (sel_q),
    .rdata (reg_rd_data)
  );

  // R5/R11: a datapath action with pointer 0 selected never touches pointer 1
  a_r5_other_untouched: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sel_q && !reg_wr_en) |=> ptrs[1] == $past(ptrs[1]));
  // R4: address output follows select bit to pointer 1
  a_r4_addr_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_q && !reg_wr_en && !ptr_load_en && !ptr_inc_en && !sel_inc_en) |=> ptr_addr == $past(ptrs[1]));
endmodule

// File: tb/dual_ptr_unit_tb_top.sv
module dual_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_data;
  logic [7:0]  reg_rd_data;
  logic [15:0] ptr_addr;
  logic        ptr_load_en;
  logic [15:0] ptr_load_val;
  logic        ptr_inc_en;
  logic        sel_inc_en;

  int errors = 0;
  int checks = 0;
  logic [15:0] mp [2];
  logic        ms;

  always #10 clk = ~clk;

  dual_ptr_unit dut_i (.*);

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    case (a)
      8'h82: return mp[0][7:0];
      8'h83: return mp[0][15:8];
      8'h84: return mp[1][7:0];
      8'h85: return mp[1][15:8];
      8'h86: return {7'b0, ms};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic ld, input logic [15:0] lv, input logic inc, input logic sinc);
    logic hit;
    @(negedge clk);
    reg_wr_en = we; reg_addr = a; reg_wr_data = d;
    ptr_load_en = ld; ptr_load_val = lv; ptr_inc_en = inc; sel_inc_en = sinc;
    #1;
    chk({tag, " rd"}, {8'h00, reg_rd_data}, {8'h00, model_rd(a)});
    chk({tag, " addr"}, ptr_addr, mp[ms]);
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      hit = we && (a == 8'(8'h82 + 2*i) || a == 8'(8'h83 + 2*i));
      if (hit) begin
        if (a[0] == 1'b0) mp[i][7:0] = d; else mp[i][15:8] = d;
      end else if (ms == 1'(i)) begin
        if (ld) mp[i] = lv;
        else if (inc) mp[i] = mp[i] + 16'd1;
      end
    end
    if (we && a == 8'h86) ms = d[0];
    else if (sinc) ms = ~ms;
  endtask

  task automatic idle(input string tag, input logic [7:0] a);
    step(tag, 1'b0, a, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_addr = 8'h00; reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    ptr_load_en = 1'b0; ptr_load_val = 16'h0; ptr_inc_en = 1'b0; sel_inc_en = 1'b0;
    mp[0] = 16'h0; mp[1] = 16'h0; ms = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int a = 8'h82; a <= 8'h86; a++) idle("R1 reset", 8'(a));
    step("R2 write 82", 1'b1, 8'h82, 8'h34, 1'b0, 16'h0, 1'b0, 1'b0);
    step("R2 write 83", 1'b1, 8'h83, 8'h12, 1'b0, 16'h0, 1'b0, 1'b0);
    step("R2 write 84", 1'b1, 8'h84, 8'hcd, 1'b0, 16'h0, 1'b0, 1'b0);
    step("R2 write 85", 1'b1, 8'h85, 8'hab, 1'b0, 16'h0, 1'b0, 1'b0);
    for (int a = 8'h82; a <= 8'h85; a++) idle("R2 readback", 8'(a));
    idle("R4 ptr0 out", 8'h86);
    step("R3 write ff", 1'b1, 8'h86, 8'hff, 1'b0, 16'h0, 1'b0, 1'b0);
    idle("R3 read 01 R4 ptr1", 8'h86);
    step("R3 write fe", 1'b1, 8'h86, 8'hfe, 1'b0, 16'h0, 1'b0, 1'b0);
    idle("R3 read 00", 8'h86);
    step("R7 flip", 1'b0, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, 1'b1);
    idle("R7 after flip", 8'h86);
    step("R7 flip back", 1'b0, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, 1'b1);
    step("R7 write wins", 1'b1, 8'h86, 8'h00, 1'b0, 16'h0, 1'b0, 1'b1);
    idle("R7 write wins result", 8'h86);
    step("R5 load ptr0", 1'b0, 8'h84, 8'h00, 1'b1, 16'hffff, 1'b0, 1'b0);
    idle("R5 ptr1 low kept", 8'h84);
    idle("R5 ptr1 high kept", 8'h85);
    step("R6 wrap", 1'b0, 8'h82, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0);
    idle("R6 wrap result", 8'h83);
    step("R6 carry load", 1'b0, 8'h82, 8'h00, 1'b1, 16'h00ff, 1'b0, 1'b0);
    step("R6 carry inc", 1'b0, 8'h83, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0);
    idle("R6 carry result", 8'h83);
    step("R11 flip with inc", 1'b0, 8'h84, 8'h00, 1'b0, 16'h0, 1'b1, 1'b1);
    idle("R11 result p0", 8'h82);
    step("R6 inc ptr1", 1'b0, 8'h84, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0);
    idle("R6 ptr0 untouched", 8'h82);
    step("R9 load and inc", 1'b0, 8'h84, 8'h00, 1'b1, 16'h5a5a, 1'b1, 1'b0);
    idle("R9 result", 8'h85);
    step("R8 write vs load", 1'b1, 8'h84, 8'h77, 1'b1, 16'h1111, 1'b0, 1'b0);
    idle("R8 low", 8'h84);
    idle("R8 high", 8'h85);
    step("R8 other ptr write", 1'b1, 8'h82, 8'h99, 1'b0, 16'h0, 1'b1, 1'b0);
    idle("R8 other ptr result", 8'h82);
    idle("R10 read 80", 8'h80);
    idle("R10 read 87", 8'h87);
    idle("R10 read ff", 8'hff);
    step("R10 write 81 ignored", 1'b1, 8'h81, 8'h55, 1'b0, 16'h0, 1'b0, 1'b0);
    idle("R10 after write", 8'h81);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule